// File: doc/BRIEF.md
# Oversampled SPI Receive Slave

This block is an SPI slave clocked entirely by the system reference clock. An external master drives the serial clock, the active-low select and the master-out data line. The block samples all three through two-flop synchronizers and finds serial clock edges in the reference domain, so the serial clock has to run well below the reference clock. One configuration input sets the idle level of the serial clock and another sets the phase. Together they pick which edge captures data and which edge moves the slave output.

Bits are captured MSB first into a shift register. A word is complete when the programmed number of bits has been captured, or when the select goes inactive part way through a word, whichever happens first. The completed word is copied into a receive register. The copy sets a pending flag and can pulse an interrupt. A copy that lands on an unread word overwrites that word and sets a sticky overrun bit. The slave output sends the shift register contents MSB first, so each frame carries back the bits received before it. The output enable is active only while the slave is selected.

Top module: `spi_rx_slave`

## Requirements
- R1: The capture edge is the rising serial clock edge when idle level equals phase, and the falling edge otherwise. Bits are captured MSB first, and a completed word sits in the low bits of the receive data with the upper bits zero.
- R2: After word-length captures within one select period, a word completes and the bit count starts again from zero. Several words can complete in a single select period.
- R3: A word-length value of 0 or above the data width W is treated as W.
- R4: If the select goes inactive with 1 to length-1 bits captured, the partial word completes and is copied as the shift register masked to the word length. If it goes inactive with 0 bits pending, nothing is copied.
- R5: Every copy sets rx_valid_o. A read strobe clears rx_valid_o. When a copy and a read fall in the same cycle, the copy takes priority.
- R6: When the interrupt enable is set, irq_o pulses high for exactly one cycle on each copy. When it is clear, irq_o stays low.
- R7: A copy made while rx_valid_o is set and no read is strobed in that cycle overwrites the data and sets ovr_o. ovr_o stays set until ovr_clr_i is pulsed.
- R8: miso_o carries bit length-1 of the shift register. It is loaded when the select becomes active and reloaded on every non-capture edge, so the master receives the previous shift register contents MSB first.
- R9: While deselected, miso_oe_o is low and serial clock and data activity has no effect on the bit count, the shift register or the receive register.
- R10: After reset, rx_valid_o, ovr_o, irq_o, miso_oe_o and rx_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| sel_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Serial data from the master |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase: 0 captures on the leading edge, 1 on the trailing edge |
| word_len_i | input | $clog2(W+1) | Bits per word, 1..W (0 or above W means W) |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Receive register read strobe |
| ovr_clr_i | input | 1 | Clears the overrun bit |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for miso_o |
| rx_data_o | output | W | Receive data register |
| rx_valid_o | output | 1 | Unread word pending |
| irq_o | output | 1 | Word-complete interrupt pulse |
| ovr_o | output | 1 | Sticky overrun status |

## Verification
The assertions assume three things about the inputs. Serial clock edges are several reference cycles apart. No serial clock edge arrives in the same few cycles as a change of the select. The idle level, phase and word length do not change while the slave is selected. The stimulus holds each serial clock level for four to eight reference cycles, waits eight cycles on each side of every select change, and changes configuration only between frames. The random frames vary mode, word length and bit count, including counts that end mid-word and counts that span several words.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  typedef struct packed {
    logic active;   // selected
    logic sample;   // capture edge
    logic shift;    // output update edge
    logic sel_on;   // select became active
    logic sel_off;  // select became inactive
  } spi_evt_t;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
  parameter int          WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spi_rx_edge.sv
module spi_rx_edge
  import spi_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sclk_s_i,
  input  logic     sel_s_i,
  input  logic     cpol_i,
  input  logic     cpha_i,
  output spi_evt_t evt_o
);
  logic sclk_q, sel_q;
  logic rise, fall, cap_on_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sel_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      sel_q  <= sel_s_i;
    end
  end

  assign rise        = sclk_s_i & ~sclk_q;
  assign fall        = ~sclk_s_i & sclk_q;
  assign cap_on_rise = ~(cpol_i ^ cpha_i);

  always_comb begin
    evt_o.active  = ~sel_s_i;
    evt_o.sample  = ~sel_s_i & (cap_on_rise ? rise : fall);
    evt_o.shift   = ~sel_s_i & (cap_on_rise ? fall : rise);
    evt_o.sel_on  = ~sel_s_i & sel_q;
    evt_o.sel_off = sel_s_i & ~sel_q;
  end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_rx_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  spi_evt_t      evt_i,
  input  logic          mosi_s_i,
  input  logic [CW-1:0] len_i,
  output logic          done_o,
  output logic [W-1:0]  word_o,
  output logic [CW-1:0] cnt_o,
  output logic          miso_o
);
  logic [W-1:0]  sr_q, sr_nxt, mask;
  logic [CW-1:0] cnt_q, last_idx;
  logic          top_bit, miso_q, at_last;

  assign last_idx = len_i - 1'b1;
  assign at_last  = (cnt_q == last_idx);
  assign sr_nxt   = {sr_q[W-2:0], mosi_s_i};

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign mask[g] = (CW'(g) < len_i);
  end

  always_comb begin
    top_bit = 1'b0;
    for (int i = 0; i < W; i++)
      if (CW'(i) == last_idx) top_bit = sr_q[i];
  end

  assign done_o = (evt_i.sample & at_last) | (evt_i.sel_off & (cnt_q != '0));
  assign word_o = (evt_i.sample ? sr_nxt : sr_q) & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      miso_q <= 1'b0;
    end else begin
      if (evt_i.sel_on || evt_i.sel_off) begin
        cnt_q <= '0;
      end else if (evt_i.sample) begin
        sr_q  <= sr_nxt;
        cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      end
      if (evt_i.sel_on || evt_i.shift) miso_q <= top_bit;
    end
  end

  assign cnt_o  = cnt_q;
  assign miso_o = miso_q;
endmodule

// File: rtl/spi_rx_slave.sv
module spi_rx_slave
  import spi_rx_pkg::*;
#(
  parameter  int W  = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sel_ni,
  input  logic          mosi_i,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic [CW-1:0] word_len_i,
  input  logic          irq_en_i,
  input  logic          rd_i,
  input  logic          ovr_clr_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  output logic [W-1:0]  rx_data_o,
  output logic          rx_valid_o,
  output logic          irq_o,
  output logic          ovr_o
);
  logic [2:0]    sync_q;
  spi_evt_t      evt;
  logic [CW-1:0] len_eff, bit_cnt;
  logic          word_done, ovr_set;
  logic [W-1:0]  word;
  logic [W-1:0]  rx_data_q;
  logic          valid_q, ovr_q, irq_q;

  spi_rx_sync #(.WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, sel_ni, sclk_i}),
    .q_o   (sync_q)
  );

  spi_rx_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(sync_q[0]),
    .sel_s_i (sync_q[1]),
    .cpol_i  (cpol_i),
    .cpha_i  (cpha_i),
    .evt_o   (evt)
  );

  assign len_eff = (word_len_i == '0 || word_len_i > CW'(W)) ? CW'(W) : word_len_i;

  spi_rx_shift #(.W(W), .CW(CW)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .mosi_s_i(sync_q[2]),
    .len_i   (len_eff),
    .done_o  (word_done),
    .word_o  (word),
    .cnt_o   (bit_cnt),
    .miso_o  (miso_o)
  );

  assign ovr_set = word_done & valid_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_q <= '0;
      valid_q   <= 1'b0;
      ovr_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= word_done & irq_en_i;
      if (word_done) begin
        rx_data_q <= word;
        valid_q   <= 1'b1;
      end else if (rd_i) begin
        valid_q   <= 1'b0;
      end
      if (ovr_set)        ovr_q <= 1'b1;
      else if (ovr_clr_i) ovr_q <= 1'b0;
    end
  end

  assign miso_oe_o  = evt.active;
  assign rx_data_o  = rx_data_q;
  assign rx_valid_o = valid_q;
  assign irq_o      = irq_q;
  assign ovr_o      = ovr_q;
endmodule

// File: rtl/spi_rx_slave_chk.sv
module spi_rx_slave_chk #(
  parameter int W  = 8,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_ni,
  input logic          irq_en_i,
  input logic          rd_i,
  input logic          ovr_clr_i,
  input logic          miso_oe_o,
  input logic [W-1:0]  rx_data_o,
  input logic          rx_valid_o,
  input logic          irq_o,
  input logic          ovr_o,
  input logic          word_done,
  input logic [CW-1:0] bit_cnt,
  input logic [CW-1:0] len_eff
);
  a_r6_irq_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));
  a_r6_irq_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> rx_valid_o);
  a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !word_done) |=> !rx_valid_o);
  a_r5_copy_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |=> rx_valid_o);
  a_r7_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !ovr_clr_i) |=> ovr_o);
  a_r7_ovr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(word_done && rx_valid_o));
  a_r2_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_done |=> $stable(rx_data_o));
  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt < len_eff);
  a_r9_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni && $past(sel_ni) && $past(sel_ni, 2) && $past(sel_ni, 3)) |-> !miso_oe_o);
endmodule

bind spi_rx_slave spi_rx_slave_chk #(.W(W), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_ni    (sel_ni),
  .irq_en_i  (irq_en_i),
  .rd_i      (rd_i),
  .ovr_clr_i (ovr_clr_i),
  .miso_oe_o (miso_oe_o),
  .rx_data_o (rx_data_o),
  .rx_valid_o(rx_valid_o),
  .irq_o     (irq_o),
  .ovr_o     (ovr_o),
  .word_done (word_done),
  .bit_cnt   (bit_cnt),
  .len_eff   (len_eff)
);

// File: tb/spi_rx_slave_tb.sv
module spi_rx_slave_tb;
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, sel_n = 1'b1, mosi = 1'b0;
  logic          cpol = 1'b0, cpha = 1'b0;
  logic [CW-1:0] len_r = CW'(W);
  logic          irq_en = 1'b0, rd = 1'b0, ovr_clr = 1'b0;
  logic          miso, miso_oe, rx_valid, irq, ovr;
  logic [W-1:0]  rx_data;

  int checks = 0, errors = 0;
  int irq_seen = 0, irq_exp = 0;
  logic [W-1:0] sr_m = '0, data_m = '0;
  logic valid_m = 1'b0, ovr_m = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_rx_slave #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sel_ni(sel_n), .mosi_i(mosi),
    .cpol_i(cpol), .cpha_i(cpha), .word_len_i(len_r), .irq_en_i(irq_en),
    .rd_i(rd), .ovr_clr_i(ovr_clr), .miso_o(miso), .miso_oe_o(miso_oe),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .irq_o(irq), .ovr_o(ovr)
  );

  always @(negedge clk) if (rst_n && irq) irq_seen++;

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff_len(input logic [CW-1:0] l);
    return (l == 0 || l > CW'(W)) ? W : int'(l);
  endfunction

  function automatic logic [W-1:0] len_mask(input int le);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < le);
    return m;
  endfunction

  task automatic push_word(input int le);
    if (valid_m) ovr_m = 1'b1;
    data_m  = sr_m & len_mask(le);
    valid_m = 1'b1;
    if (irq_en) irq_exp++;
  endtask

  // one select period of nbits bits, MSB first
  task automatic frame(input int nbits, input logic [31:0] bits);
    int le, cnt;
    logic b;
    le = eff_len(len_r);
    cnt = 0;
    sclk = cpol;
    wc(8);
    sel_n = 1'b0;
    wc(8);
    chk(miso_oe == 1'b1, "R9 oe while selected", miso_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      b = bits[nbits-1-i];
      if (!cpha) begin
        mosi = b; wc(8);
        chk(miso == sr_m[le-1], "R8 miso bit", miso, sr_m[le-1]);
        sclk = ~cpol; wc(8);
        sclk = cpol;
      end else begin
        sclk = ~cpol; wc(4);
        mosi = b; wc(4);
        chk(miso == sr_m[le-1], "R8 miso bit", miso, sr_m[le-1]);
        sclk = cpol; wc(8);
      end
      sr_m = {sr_m[W-2:0], b};
      cnt++;
      if (cnt == le) begin
        push_word(le);  // R2 word by count
        cnt = 0;
      end
    end
    if (!cpha) wc(8);
    sel_n = 1'b1;
    if (cnt > 0) push_word(le);  // R4 partial word
    wc(8);
    chk(miso_oe == 1'b0, "R9 oe off after deselect", miso_oe, 0);
    chk(irq_seen == irq_exp, "R6 irq pulse count", irq_seen, irq_exp);
    chk(rx_valid == valid_m, "R5 valid after frame", rx_valid, valid_m);
  endtask

  task automatic do_read(input string req);
    chk(rx_valid == valid_m, "R5 valid before read", rx_valid, valid_m);
    if (valid_m) chk(rx_data == data_m, req, rx_data, data_m);
    rd = 1'b1; wc(1); rd = 1'b0;
    valid_m = 1'b0;
    wc(2);
    chk(rx_valid == 1'b0, "R5 read clears valid", rx_valid, 0);
  endtask

  task automatic ovr_check_clear();
    chk(ovr == ovr_m, "R7 overrun flag", ovr, ovr_m);
    ovr_clr = 1'b1; wc(1); ovr_clr = 1'b0;
    ovr_m = 1'b0;
    wc(2);
    chk(ovr == 1'b0, "R7 overrun clear", ovr, 0);
  endtask

  initial begin
    void'($urandom(32'h5a17));
    wc(3);
    rst_n = 1'b1;
    wc(3);
    // R10 reset state
    chk(rx_valid == 0 && ovr == 0 && irq == 0, "R10 status after reset", {rx_valid, ovr, irq}, 0);
    chk(miso_oe == 0, "R10 oe after reset", miso_oe, 0);
    chk(rx_data == 0, "R10 data after reset", rx_data, 0);

    // R1 mode 0, full word
    cpol = 0; cpha = 0; len_r = 8; irq_en = 1;
    frame(8, 32'hA5);
    do_read("R1 mode0 word");
    // R1/R8 mode 3, echoes previous word on miso
    cpol = 1; cpha = 1;
    frame(8, 32'h3C);
    do_read("R1 mode3 word");
    // R2/R7 two words in one select, no read between
    cpol = 0; cpha = 1; len_r = 4;
    frame(8, 32'h9E);
    ovr_check_clear();
    do_read("R2 second word of frame");
    // R3 length 0 means W
    cpol = 1; cpha = 0; len_r = 0; irq_en = 0;
    frame(8, 32'hC3);
    do_read("R3 length zero word");
    // R4 partial word on early deselect
    len_r = 8; irq_en = 1;
    frame(3, 32'h5);
    do_read("R4 partial word");
    // R4 deselect with nothing pending: no copy
    frame(0, 0);
    chk(rx_valid == 1'b0, "R4 empty frame no copy", rx_valid, 0);
    // R9 activity while deselected is ignored
    for (int i = 0; i < 10; i++) begin
      sclk = ~sclk; mosi = $urandom; wc(6);
    end
    chk(rx_valid == 1'b0, "R9 idle activity no copy", rx_valid, 0);
    cpol = 0; cpha = 0;
    frame(8, 32'h81);
    do_read("R9 word after idle activity");

    // random frames
    for (int n = 0; n < 40; n++) begin
      int le, nb;
      cpol   = $urandom;
      cpha   = $urandom;
      len_r  = CW'($urandom % (W + 2));
      irq_en = $urandom;
      le = eff_len(len_r);
      nb = $urandom % (2 * le + 1);
      frame(nb, $urandom);
      if ($urandom % 2) do_read("R2 random word");
      if ($urandom % 3 == 0) ovr_check_clear();
    end
    ovr_check_clear();
    do_read("R1 final word");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule